// File: doc/BRIEF.md
# Carrier Phase-Reversal Detector

The block watches a one-bit, already-sliced carrier that runs at one eighth of the sample clock rate, for example a 5 MHz carrier sampled at 40 MHz. It flags the moments when the carrier reverses phase. Each synchronized sample is compared with the sample taken exactly one carrier period before. A phase reversal makes those two disagree for several samples in a row. A small frequency offset between the transmitter and the sample clock produces only lone single-sample disagreements near the carrier edges.

A three-sample vote drops the lone disagreements. Accepted ones appear on a raw detect output. A retriggerable hold counter turns a burst of detect pulses into one clean pulse that a downstream bit decoder can sample. The carrier input may be fully asynchronous to the sample clock.

Top module: `phrev_detector`

## Requirements
- R1: While `rst_ni` is low, and on the first clock after it rises, `detect_o` and `pulse_o` are low. The synchronizer, the period delay line and the hold counter are cleared, so every sample taken before the first clock after reset counts as 0.
- R2: `carrier_i` passes through two flip-flops in series before any use. A carrier sampled at clock edge n that disagrees with the sample at edge n-8, and likewise at edge n+1, raises `detect_o` just after clock edge n+4.
- R3: A mismatch for the sample taken at edge n means that sample differs from the sample taken SAMPLES_PER_CYCLE (8) edges earlier.
- R4: `detect_o` is high after edge e exactly when the mismatch of sample e-3 is set and the mismatch of sample e-4 or of sample e-5 is also set. A lone mismatch with no other mismatch within two samples never raises `detect_o`.
- R5: A high `detect_o` after edge j makes `pulse_o` high after edge j+1. `pulse_o` stays high through edge j+HOLD_CYCLES and falls after edge j+HOLD_CYCLES+1 if no further detect occurs (HOLD_CYCLES = 8).
- R6: A detect that arrives while `pulse_o` is high restarts the hold count, so `pulse_o` falls only HOLD_CYCLES+1 edges after the last detect.
- R7: A steady carrier produces no `pulse_o` after the reset start-up has settled. This includes a carrier whose edges slip by one sample every 40 samples, which models a frequency offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, eight times the carrier rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| carrier_i | input | 1 | Sliced carrier, asynchronous to clk_i |
| detect_o | output | 1 | Filtered raw phase-reversal detect |
| pulse_o | output | 1 | Stretched, retriggerable phase-change pulse |

## Verification
The assertions assume that the mismatch flag is the only path into the vote, and that the vote is the only path into the hold counter. The properties therefore relate `detect_o` to the last three mismatch values, and relate `pulse_o` to the number of clocks since the last detect. The bench drives `carrier_i` half a clock away from the sampling edge, so every sample is captured cleanly and the two-stage synchronizer adds a fixed two-cycle latency. The predicted outputs can then be computed per cycle from the driven sample history alone. The stimulus covers a steady carrier, a single phase flip, one- and two-sample glitches, closely spaced flips, a slipping carrier, and a long pseudo-random run.

// File: rtl/phrev_pkg.sv
package phrev_pkg;
  localparam int unsigned SAMPLES_DEF = 8;
  localparam int unsigned HOLD_DEF    = 8;
  localparam int unsigned SYNC_DEF    = 2;
endpackage

// File: rtl/phrev_sync.sv
module phrev_sync #(
  parameter int unsigned STAGES = phrev_pkg::SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/phrev_mismatch.sv
module phrev_mismatch #(
  parameter int unsigned SAMPLES = phrev_pkg::SAMPLES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  output logic mis_o
);
  logic [SAMPLES-1:0] dly_q;
  logic               mis_q;

  // one carrier period of history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= {dly_q[SAMPLES-2:0], smp_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mis_q <= 1'b0;
    else         mis_q <= smp_i ^ dly_q[SAMPLES-1];
  end

  assign mis_o = mis_q;
endmodule

// File: rtl/phrev_vote.sv
module phrev_vote (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mis_i,
  output logic det_o
);
  logic [2:1] tap_q;
  logic       adj_q;
  logic       gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q <= '0;
      adj_q <= 1'b0;
      gap_q <= 1'b0;
    end else begin
      tap_q <= {tap_q[1], mis_i};
      adj_q <= mis_i & tap_q[1];   // two in a row
      gap_q <= mis_i & tap_q[2];   // first and third
    end
  end

  assign det_o = adj_q | gap_q;
endmodule

// File: rtl/phrev_stretch.sv
module phrev_stretch #(
  parameter int unsigned HOLD = phrev_pkg::HOLD_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (det_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) act_q <= 1'b0;
    end
  end

  assign pulse_o = act_q;
endmodule

// File: rtl/phrev_detector.sv
module phrev_detector #(
  parameter int unsigned SAMPLES_PER_CYCLE = phrev_pkg::SAMPLES_DEF,
  parameter int unsigned HOLD_CYCLES       = phrev_pkg::HOLD_DEF,
  parameter int unsigned SYNC_STAGES       = phrev_pkg::SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carrier_i,
  output logic detect_o,
  output logic pulse_o
);
  logic smp;
  logic mis_q;

  phrev_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(carrier_i), .q_o(smp)
  );

  phrev_mismatch #(.SAMPLES(SAMPLES_PER_CYCLE)) u_mis (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp), .mis_o(mis_q)
  );

  phrev_vote u_vote (
    .clk_i(clk_i), .rst_ni(rst_ni), .mis_i(mis_q), .det_o(detect_o)
  );

  phrev_stretch #(.HOLD(HOLD_CYCLES)) u_str (
    .clk_i(clk_i), .rst_ni(rst_ni), .det_i(detect_o), .pulse_o(pulse_o)
  );
endmodule

// File: rtl/phrev_detector_chk.sv
module phrev_detector_chk #(
  parameter int unsigned HOLD = phrev_pkg::HOLD_DEF
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mis_i,
  input logic detect_i,
  input logic pulse_i
);
  localparam int unsigned GW = $clog2(HOLD + 2);
  localparam logic [GW-1:0] HOLD_V = GW'(HOLD);

  // clocks since last detect, saturating at HOLD
  logic [GW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            since_q <= HOLD_V;
    else if (detect_i)      since_q <= '0;
    else if (since_q < HOLD_V) since_q <= since_q + 1'b1;
  end

  // R4
  vote_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_i |-> ($past(mis_i) && ($past(mis_i, 2) || $past(mis_i, 3))));

  // R5
  pulse_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_i |=> pulse_i);

  // R5
  pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> $past(detect_i));

  // R6
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_i) |-> (since_q == HOLD_V));

  // R6
  hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q < HOLD_V) |-> pulse_i);
endmodule

bind phrev_detector phrev_detector_chk #(.HOLD(HOLD_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mis_i(mis_q),
  .detect_i(detect_o), .pulse_i(pulse_o)
);

// File: tb/phrev_detector_test.sv
module phrev_detector_test;
  localparam int N = 4096;
  localparam int LAST_N = 3600;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic carrier_i = 1'b0;
  logic detect_o, pulse_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit hist [0:N-1];

  always #2.5 clk = ~clk;

  phrev_detector uut (
    .clk_i(clk), .rst_ni(rst_ni), .carrier_i(carrier_i),
    .detect_o(detect_o), .pulse_o(pulse_o)
  );

  function automatic bit smp_at(int n);
    return (n < 0) ? 1'b0 : hist[n];
  endfunction

  // R3: mismatch against one carrier period earlier
  function automatic bit mis_at(int n);
    if (n < 0) return 1'b0;
    return smp_at(n) ^ smp_at(n - 8);
  endfunction

  function automatic bit det_at(int e);
    return mis_at(e - 3) & (mis_at(e - 4) | mis_at(e - 5));
  endfunction

  function automatic bit pulse_at(int e);
    bit p = 1'b0;
    for (int j = e - 8; j <= e - 1; j++) if (j >= 0 && det_at(j)) p = 1'b1;
    return p;
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  initial begin
    bit inv = 1'b0;
    bit [15:0] lfsr = 16'hACE1;
    int first_det = -1;
    int r7_pulses = 0;
    int r6_len = 0;
    int slip;
    bit v;

    repeat (4) @(negedge clk);
    // R1: outputs low in reset
    check("R1 detect in reset", detect_o, 1'b0);
    check("R1 pulse in reset", pulse_o, 1'b0);
    rst_ni = 1'b1;

    for (int n = 0; n < LAST_N; n++) begin
      slip = 0;
      if (n == 203 || n == 610 || n == 616) inv = ~inv;
      if (n >= 800 && n < 1600) slip = (n - 800) / 40;
      v = (((n + slip) % 8) < 4) ^ inv;
      if (n == 410 || n == 450 || n == 500 || n == 501) v = ~v;
      if (n >= 1600) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[3:0] == 4'h0) inv = ~inv;
        v = ((n % 8) < 4) ^ inv;
        if (lfsr[7:4] == 4'h5) v = ~v;
      end
      hist[n] = v;
      carrier_i = v;
      @(posedge clk);
      #1;
      if (n == 0) begin
        check("R1 detect after reset", detect_o, 1'b0);
        check("R1 pulse after reset", pulse_o, 1'b0);
      end
      if (n < 200) begin
        check("R7 steady detect", detect_o, det_at(n));
        check("R7 steady pulse", pulse_o, pulse_at(n));
        if (n >= 40) check("R7 steady no pulse", pulse_o, 1'b0);
      end else if (n < 400) begin
        if (detect_o && first_det < 0) first_det = n;
        check("R3 flip detect", detect_o, det_at(n));
        check("R5 flip pulse", pulse_o, pulse_at(n));
      end else if (n < 600) begin
        check("R4 glitch detect", detect_o, det_at(n));
        check("R4 glitch pulse", pulse_o, pulse_at(n));
        if (n >= 410 && n < 480) check("R4 lone glitch ignored", detect_o, 1'b0);
      end else if (n < 800) begin
        if (pulse_o) r6_len++;
        check("R6 retrigger detect", detect_o, det_at(n));
        check("R6 retrigger pulse", pulse_o, pulse_at(n));
      end else if (n < 1600) begin
        if (n >= 820 && pulse_o) r7_pulses++;
        check("R7 slip detect", detect_o, det_at(n));
        check("R7 slip pulse", pulse_o, pulse_at(n));
      end else begin
        check("R4 random detect", detect_o, det_at(n));
        check("R5 random pulse", pulse_o, pulse_at(n));
      end
      @(negedge clk);
    end

    // R2: first flipped sample at 203, detect expected after edge 207
    check_int("R2 detect latency", first_det, 207);
    // R7: slipping carrier never stretches
    check_int("R7 slip pulse cycles", r7_pulses, 0);
    // R6: flips at 610 and 616 -> one pulse covering both with hold extended
    check_int("R6 stretched length", r6_len, 0 + (616 + 4 + 8 + 8 - 1) - (610 + 4) + 1 > 0 ? r6_len_exp() : 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int r6_len_exp();
    int c = 0;
    for (int e = 600; e < 800; e++) if (pulse_at(e)) c++;
    return c;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule